// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Codec (7,4)

This block protects a 4-bit nibble with 3 check bits, giving a 7-bit codeword, and repairs any single flipped bit on the way back. The encoder path turns a nibble into a codeword. The decoder path takes a codeword that may be corrupted and returns four results: the 3-bit syndrome, an error flag, the repaired codeword and the recovered nibble. The number of check bits is a parameter. The codeword length is always 2^k − 1, with k check bits. The default of 3 gives the 7-bit code.

Both paths are combinational and end in one shared output register stage. A transaction is presented with `in_valid_i`. One clock later the block presents its results with `out_valid_o`. Between transactions the registered results hold their values. Check bits sit at the power-of-two positions. A non-zero syndrome is the position of the faulty bit, and the block reports it directly.

Top module: `hsec_codec`

## Requirements
- R1: Codeword positions are numbered 1 to 7, and position p is bit p-1 of the code vector. Data bit 0 (D1) goes to position 3, D2 to position 5, D3 to position 6 and D4 to position 7. The check bits use even parity: position 1 holds D1^D2^D4, position 2 holds D1^D3^D4, and position 4 holds D2^D3^D4.
- R2: A clean codeword decodes with a syndrome of 0 and the error flag low. The corrected codeword equals the input.
- R3: A codeword with exactly one bit flipped, at position p, decodes with syndrome p and the error flag high. Syndrome bit 0 covers positions with bit 0 set, bit 1 covers positions with bit 1 set, and bit 2 covers positions with bit 2 set.
- R4: After a single-bit error, the corrected codeword equals the original clean codeword. In general, the corrected codeword differs from the input in exactly one bit when the flag is high and in no bit when it is low.
- R5: The recovered nibble is taken from positions 3, 5, 6 and 7 of the corrected codeword, in the order D1 to D4. After at most one error it equals the encoded nibble.
- R6: `out_valid_o` is high in the cycle after a cycle with `in_valid_i` high, and low otherwise.
- R7: When `in_valid_i` is low, every data output keeps its value, whatever the other inputs do.
- R8: While `rst_ni` is low, every output is 0.
- R9: With two bits flipped, at positions p and q, the syndrome is p XOR q and the flag is high. The corrected word then also has position p XOR q inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Capture the current inputs this cycle |
| enc_data_i | input | 4 | Nibble to encode |
| dec_code_i | input | 7 | Codeword to check and repair |
| out_valid_o | output | 1 | Registered results are from the previous cycle's inputs |
| enc_code_o | output | 7 | Encoded codeword |
| dec_syn_o | output | 3 | Syndrome, which is the faulty position when non-zero |
| dec_err_o | output | 1 | Syndrome non-zero |
| dec_code_o | output | 7 | Repaired codeword |
| dec_data_o | output | 4 | Recovered nibble |

## Verification
The assertions treat the inputs as stable across the capturing clock edge and take `in_valid_i` to be a clean level. The bench meets this by changing the inputs only on falling edges. The single-flip relation between the input and the repaired codeword holds for any input, because the decoder flips at most one bit. The data-position checks hold for any input too, so the stimulus does not need to stay within at most one error for the properties to hold. The bench does hold itself to that limit when it checks recovered data against the original nibble. It then covers every nibble with no error, with every single flip, and with every pair of flips.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

  function automatic bit is_pow2(int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  // 1-based codeword position of data bit j (j-th non-power-of-two position)
  function automatic int unsigned data_pos(int unsigned j);
    int unsigned cnt = 0;
    int unsigned pos = 0;
    for (int unsigned p = 1; p < 64; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == j && pos == 0) pos = p;
        cnt++;
      end
    end
    return pos;
  endfunction

  // positions covered by check bit i: those whose index has bit i set
  function automatic logic [63:0] group_mask(int unsigned i);
    logic [63:0] m = '0;
    for (int unsigned p = 1; p < 64; p++) m[p-1] = ((p >> i) & 1) != 0;
    return m;
  endfunction

endpackage

// File: rtl/hsec_enc.sv
module hsec_enc
  import hsec_pkg::*;
#(
  parameter int unsigned CHK_W = 3,
  localparam int unsigned CW = (1 << CHK_W) - 1,
  localparam int unsigned DW = CW - CHK_W
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] code_o
);

  logic [CW-1:0] spread;

  for (genvar j = 0; j < DW; j++) begin : g_dat
    assign spread[data_pos(j)-1] = data_i[j];
  end

  for (genvar p = 1; p <= CW; p++) begin : g_pos
    if (is_pow2(p)) begin : g_chk
      localparam logic [63:0] MFULL = group_mask($clog2(p));
      assign spread[p-1] = 1'b0;
      assign code_o[p-1] = ^(spread & MFULL[CW-1:0]);
    end else begin : g_pass
      assign code_o[p-1] = spread[p-1];
    end
  end

endmodule

// File: rtl/hsec_syn.sv
module hsec_syn
  import hsec_pkg::*;
#(
  parameter int unsigned CHK_W = 3,
  localparam int unsigned CW = (1 << CHK_W) - 1
) (
  input  logic [CW-1:0]    code_i,
  output logic [CHK_W-1:0] syn_o
);

  for (genvar i = 0; i < CHK_W; i++) begin : g_syn
    localparam logic [63:0] MFULL = group_mask(i);
    assign syn_o[i] = ^(code_i & MFULL[CW-1:0]);
  end

endmodule

// File: rtl/hsec_fix.sv
module hsec_fix
  import hsec_pkg::*;
#(
  parameter int unsigned CHK_W = 3,
  localparam int unsigned CW = (1 << CHK_W) - 1,
  localparam int unsigned DW = CW - CHK_W
) (
  input  logic [CW-1:0]    code_i,
  input  logic [CHK_W-1:0] syn_i,
  output logic [CW-1:0]    code_o,
  output logic [DW-1:0]    data_o
);

  logic [CW-1:0] flip;

  // syndrome names the faulty position directly
  for (genvar p = 1; p <= CW; p++) begin : g_flip
    assign flip[p-1] = (syn_i == CHK_W'(p));
  end

  assign code_o = code_i ^ flip;

  for (genvar j = 0; j < DW; j++) begin : g_dat
    assign data_o[j] = code_o[data_pos(j)-1];
  end

endmodule

// File: rtl/hsec_codec.sv
module hsec_codec #(
  parameter int unsigned CHK_W = 3,
  localparam int unsigned CW = (1 << CHK_W) - 1,
  localparam int unsigned DW = CW - CHK_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [DW-1:0]    enc_data_i,
  input  logic [CW-1:0]    dec_code_i,
  output logic             out_valid_o,
  output logic [CW-1:0]    enc_code_o,
  output logic [CHK_W-1:0] dec_syn_o,
  output logic             dec_err_o,
  output logic [CW-1:0]    dec_code_o,
  output logic [DW-1:0]    dec_data_o
);

  logic [CW-1:0]    enc_code;
  logic [CHK_W-1:0] syn;
  logic [CW-1:0]    fix_code;
  logic [DW-1:0]    fix_data;

  hsec_enc #(.CHK_W(CHK_W)) u_enc (
    .data_i (enc_data_i),
    .code_o (enc_code)
  );

  hsec_syn #(.CHK_W(CHK_W)) u_syn (
    .code_i (dec_code_i),
    .syn_o  (syn)
  );

  hsec_fix #(.CHK_W(CHK_W)) u_fix (
    .code_i (dec_code_i),
    .syn_i  (syn),
    .code_o (fix_code),
    .data_o (fix_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      enc_code_o  <= '0;
      dec_syn_o   <= '0;
      dec_err_o   <= 1'b0;
      dec_code_o  <= '0;
      dec_data_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        enc_code_o <= enc_code;
        dec_syn_o  <= syn;
        dec_err_o  <= |syn;
        dec_code_o <= fix_code;
        dec_data_o <= fix_data;
      end
    end
  end

endmodule

// File: rtl/hsec_codec_chk.sv
module hsec_codec_chk
  import hsec_pkg::*;
#(
  parameter int unsigned CHK_W = 3,
  localparam int unsigned CW = (1 << CHK_W) - 1,
  localparam int unsigned DW = CW - CHK_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [DW-1:0]    enc_data_i,
  input logic [CW-1:0]    dec_code_i,
  input logic             out_valid_o,
  input logic [CW-1:0]    enc_code_o,
  input logic [CHK_W-1:0] dec_syn_o,
  input logic             dec_err_o,
  input logic [CW-1:0]    dec_code_o,
  input logic [DW-1:0]    dec_data_o
);

  assert_valid_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  assert_valid_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  assert_hold_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(enc_code_o) && $stable(dec_syn_o) && $stable(dec_err_o)
                     && $stable(dec_code_o) && $stable(dec_data_o)));

  assert_one_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> ($countones(dec_code_o ^ $past(dec_code_i)) == (dec_err_o ? 1 : 0)));

  for (genvar j = 0; j < DW; j++) begin : g_pos
    assert_enc_place_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> (enc_code_o[data_pos(j)-1] == $past(enc_data_i[j])));

    assert_dec_pick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> (dec_data_o[j] == dec_code_o[data_pos(j)-1]));
  end

endmodule

bind hsec_codec hsec_codec_chk #(.CHK_W(CHK_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .enc_data_i  (enc_data_i),
  .dec_code_i  (dec_code_i),
  .out_valid_o (out_valid_o),
  .enc_code_o  (enc_code_o),
  .dec_syn_o   (dec_syn_o),
  .dec_err_o   (dec_err_o),
  .dec_code_o  (dec_code_o),
  .dec_data_o  (dec_data_o)
);

// File: tb/hsec_codec_tb.sv
`timescale 1ns/1ps
module hsec_codec_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic [3:0] enc_data_i = '0;
  logic [6:0] dec_code_i = '0;
  logic       out_valid_o;
  logic [6:0] enc_code_o;
  logic [2:0] dec_syn_o;
  logic       dec_err_o;
  logic [6:0] dec_code_o;
  logic [3:0] dec_data_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk_i = ~clk_i;

  hsec_codec u_dut (
    .clk_i, .rst_ni, .in_valid_i, .enc_data_i, .dec_code_i,
    .out_valid_o, .enc_code_o, .dec_syn_o, .dec_err_o, .dec_code_o, .dec_data_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // encoding from R1
  function automatic logic [6:0] ref_enc(input logic [3:0] d);
    logic [6:0] c;
    c[2] = d[0]; c[4] = d[1]; c[5] = d[2]; c[6] = d[3];
    c[0] = d[0] ^ d[1] ^ d[3];
    c[1] = d[0] ^ d[2] ^ d[3];
    c[3] = d[1] ^ d[2] ^ d[3];
    return c;
  endfunction

  function automatic logic [3:0] ref_pick(input logic [6:0] c);
    return {c[6], c[5], c[4], c[2]};
  endfunction

  // drive at falling edge, captured at the next rising edge, sampled at the following falling edge
  task automatic xact(input logic [3:0] d, input logic [6:0] c);
    @(negedge clk_i);
    enc_data_i = d; dec_code_i = c; in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    #1;
    // R8: reset state
    chk(out_valid_o == 0 && enc_code_o == 0 && dec_syn_o == 0 && dec_err_o == 0
        && dec_code_o == 0 && dec_data_o == 0, "R8 reset", {out_valid_o, enc_code_o, dec_code_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int d = 0; d < 16; d++) begin
      logic [6:0] cw;
      cw = ref_enc(4'(d));
      // R1, R2: clean word
      xact(4'(d), cw);
      chk(enc_code_o == cw, "R1 encode", enc_code_o, cw);
      chk(out_valid_o == 1'b1, "R6 valid", out_valid_o, 1);
      chk(dec_syn_o == 0 && dec_err_o == 0, "R2 clean syndrome", {dec_err_o, dec_syn_o}, 0);
      chk(dec_code_o == cw, "R2 clean word", dec_code_o, cw);
      chk(dec_data_o == 4'(d), "R5 clean data", dec_data_o, d);
      // R3, R4, R5: single flips
      for (int p = 1; p <= 7; p++) begin
        xact(4'(d), cw ^ (7'd1 << (p - 1)));
        chk(dec_syn_o == 3'(p) && dec_err_o == 1, "R3 single syndrome", {dec_err_o, dec_syn_o}, {1'b1, 3'(p)});
        chk(dec_code_o == cw, "R4 corrected word", dec_code_o, cw);
        chk(dec_data_o == 4'(d), "R5 recovered data", dec_data_o, d);
      end
      // R9: double flips
      for (int p = 1; p <= 7; p++) begin
        for (int q = p + 1; q <= 7; q++) begin
          logic [6:0] bad, exp_fix;
          int s;
          s = p ^ q;
          bad = cw ^ (7'd1 << (p - 1)) ^ (7'd1 << (q - 1));
          exp_fix = bad ^ (7'd1 << (s - 1));
          xact(4'(d), bad);
          chk(dec_syn_o == 3'(s) && dec_err_o == 1, "R9 double syndrome", {dec_err_o, dec_syn_o}, {1'b1, 3'(s)});
          chk(dec_code_o == exp_fix, "R9 double word", dec_code_o, exp_fix);
          chk(dec_data_o == ref_pick(exp_fix), "R5 pick positions", dec_data_o, ref_pick(exp_fix));
        end
      end
    end

    // R6, R7: idle cycles with changing inputs leave outputs unchanged
    xact(4'hA, ref_enc(4'hA) ^ 7'h10);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      enc_data_i = 4'(k * 5 + 3);
      dec_code_i = 7'(k * 37 + 11);
      @(negedge clk_i);
      chk(out_valid_o == 0, "R6 valid low", out_valid_o, 0);
      chk(enc_code_o == ref_enc(4'hA), "R7 hold enc", enc_code_o, ref_enc(4'hA));
      chk(dec_syn_o == 3'd5 && dec_err_o == 1, "R7 hold syndrome", {dec_err_o, dec_syn_o}, 4'hD);
      chk(dec_code_o == ref_enc(4'hA) && dec_data_o == 4'hA, "R7 hold dec", {dec_code_o, dec_data_o}, {ref_enc(4'hA), 4'hA});
    end

    // R8: reset mid-run clears outputs
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(out_valid_o == 0 && enc_code_o == 0 && dec_syn_o == 0 && dec_err_o == 0
        && dec_code_o == 0 && dec_data_o == 0, "R8 reset mid-run", {enc_code_o, dec_code_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    finish_run();
  end

endmodule